// File: doc/BRIEF.md
# Maskable Interrupt Entry Sequencer

This block is the part of a small 8-bit processor core that turns an active-low interrupt request into the fixed bus sequence that enters the handler. Each rising edge of `clk` stands for the end of one processor cycle, which is the edge where the request pin is sampled. A request counts as pending only after it has been seen low at `SEEN_EDGES` successive cycle ends. A request that arrives too late for one edge is first seen at the next one.

While the request is pending and the disable flag is clear, the sequencer waits for the instruction stub to mark an instruction boundary. It then runs seven bus cycles:
- two dummy reads at the program counter;
- three stack writes: the counter high byte, the counter low byte, then the status with the break bit clear;
- two reads of the vector, low byte then high byte.

In the cycle after that, it presents the new program counter, the adjusted stack pointer and the status with the disable bit set. The instruction stub drives the boundary strobe, the flag and the register values, and it takes the results back.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset `entry_busy` is 0, `bus_rnw` is 1, `bus_addr` and `bus_wdata` are 0 and `entry_done` is 0.
- R2: `irq_n` is sampled at every rising clock edge, and a request becomes pending only once it has been sampled low at 2 successive edges. A pending request is lost as soon as `irq_n` is sampled high, so a low pulse seen at a single edge never starts an entry.
- R3: Entry starts only at an edge where `insn_done` is 1 and the request was already pending during the cycle ending at that edge. The first entry cycle is the cycle after that edge. While `insn_done` stays 0, no entry starts.
- R4: Entry does not start at an edge where `irq_disable` is 1.
- R5: Entry cycles 1 and 2 are reads (`bus_rnw`=1) at the program counter captured at the start edge.
- R6: Entry cycles 3, 4 and 5 are writes (`bus_rnw`=0). Their addresses are 0x0100+SP, 0x0100+SP-1 and 0x0100+SP-2, where SP is the captured stack pointer and the low byte wraps modulo 256. They write, in that order, PC[15:8], PC[7:0], and the captured status with bit 4 forced to 0.
- R7: Entry cycles 6 and 7 are reads at 0xFFFE and then 0xFFFF. The byte read in cycle 6 becomes bits 7:0 of the new program counter, and the byte read in cycle 7 becomes bits 15:8.
- R8: In the cycle after entry cycle 7, `entry_done` is 1 for exactly one cycle. In that cycle `vector_pc` holds the loaded address, `sp_out` holds SP-3 modulo 256, and `status_out` holds the captured status with bit 2 set and bit 4 cleared.
- R9: Changes on `pc_in`, `sp_in` and `status_in` after the start edge do not affect any bus cycle or result of that entry.
- R10: No new entry starts while an entry is running, nor at the edge that ends the `entry_done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock; the rising edge is the end of a processor cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_n | input | 1 | Active-low interrupt request |
| irq_disable | input | 1 | Interrupt-disable flag from the status register |
| insn_done | input | 1 | Current cycle is the last cycle of an instruction |
| pc_in | input | 16 | Program counter of the next instruction |
| sp_in | input | 8 | Stack pointer |
| status_in | input | 8 | Status register |
| bus_rdata | input | 8 | Read data for the current bus cycle |
| bus_addr | output | 16 | Bus address during entry, 0 otherwise |
| bus_rnw | output | 1 | 1 = read, 0 = write |
| bus_wdata | output | 8 | Write data during push cycles, 0 otherwise |
| entry_busy | output | 1 | An entry bus cycle is in progress |
| entry_done | output | 1 | One-cycle strobe; the results below are valid |
| vector_pc | output | 16 | Loaded handler address |
| sp_out | output | 8 | Stack pointer after the three pushes |
| status_out | output | 8 | Status with the disable bit set |

## Verification
The bench builds the block with its defaults: two sampling edges, 8-bit data, stack page 0x01 and vector 0xFFFE. At these values a one-edge pulse, a masked request and a boundary that is held off for several cycles all come down to a few cycles of stimulus. A stack pointer of 0x01 makes the push addresses wrap through 0x0100 to 0x01FF within one entry. Random per-cycle register values exercise the capture at the start edge. Random request runs produce latencies from the minimum of two cycles up to long waits for a boundary.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_DUMMY1  = 3'd1,
    PH_DUMMY2  = 3'd2,
    PH_PUSH_HI = 3'd3,
    PH_PUSH_LO = 3'd4,
    PH_PUSH_ST = 3'd5,
    PH_VEC_LO  = 3'd6,
    PH_VEC_HI  = 3'd7
  } phase_e;
endpackage

// File: rtl/irq_req_sampler.sv
module irq_req_sampler #(
  parameter int unsigned SEEN_EDGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_n,
  output logic pending
);
  localparam int unsigned CW = $clog2(SEEN_EDGES + 1);
  localparam logic [CW-1:0] CMAX = CW'(SEEN_EDGES);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (irq_n)              cnt_d = '0;
    else if (cnt_q == CMAX) cnt_d = cnt_q;
    else                    cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pending = (cnt_q == CMAX);

  // R2: pending only follows a low sample at the previous edge
  a_r2_low_before_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !$past(irq_n));
  // R2: a high sample drops the request
  a_r2_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n |=> !pending);
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pending,
  input  logic   irq_disable,
  input  logic   insn_done,
  output phase_e phase,
  output logic   start,
  output logic   busy,
  output logic   done
);
  phase_e phase_q, phase_d;
  logic   done_q, done_d;

  always_comb begin
    start  = (phase_q == PH_IDLE) && !done_q && insn_done && pending && !irq_disable;
    done_d = (phase_q == PH_VEC_HI);
    unique case (phase_q)
      PH_IDLE:    phase_d = start ? PH_DUMMY1 : PH_IDLE;
      PH_DUMMY1:  phase_d = PH_DUMMY2;
      PH_DUMMY2:  phase_d = PH_PUSH_HI;
      PH_PUSH_HI: phase_d = PH_PUSH_LO;
      PH_PUSH_LO: phase_d = PH_PUSH_ST;
      PH_PUSH_ST: phase_d = PH_VEC_LO;
      PH_VEC_LO:  phase_d = PH_VEC_HI;
      default:    phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  assign phase = phase_q;
  assign busy  = (phase_q != PH_IDLE);
  assign done  = done_q;

  // R3: entry begins only after a boundary edge
  a_r3_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(insn_done));
  // R4: a set disable flag blocks the start
  a_r4_masked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(irq_disable));
  // R8: the last fetch cycle is followed by the done strobe
  a_r8_done_after_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_VEC_HI) |=> (done_q && !busy));
  // R10: no restart in the done cycle
  a_r10_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !busy);
  // R8: done is a single-cycle strobe
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/irq_entry_datapath.sv
module irq_entry_datapath
  import irq_seq_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VEC_ADDR   = 16'hFFFE,
  parameter int unsigned I_BIT      = 2,
  parameter int unsigned B_BIT      = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  phase_e              phase,
  input  logic                start,
  input  logic [2*DATA_W-1:0] pc_in,
  input  logic [DATA_W-1:0]   sp_in,
  input  logic [DATA_W-1:0]   status_in,
  input  logic [DATA_W-1:0]   bus_rdata,
  output logic [2*DATA_W-1:0] bus_addr,
  output logic                bus_rnw,
  output logic [DATA_W-1:0]   bus_wdata,
  output logic [2*DATA_W-1:0] vector_pc,
  output logic [DATA_W-1:0]   sp_out,
  output logic [DATA_W-1:0]   status_out
);
  localparam int unsigned ADDR_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] PAGE    = DATA_W'(STACK_PAGE);
  localparam logic [ADDR_W-1:0] VEC_LO_A = ADDR_W'(VEC_ADDR);
  localparam logic [ADDR_W-1:0] VEC_HI_A = VEC_LO_A + ADDR_W'(1);
  localparam logic [DATA_W-1:0] B_MASK  = DATA_W'(1) << B_BIT;
  localparam logic [DATA_W-1:0] I_MASK  = DATA_W'(1) << I_BIT;

  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] sp_q, st_q, lo_q;
  logic [ADDR_W-1:0] vec_q;
  logic [DATA_W-1:0] spo_q, sto_q;
  logic              cap_en, lo_en, fin_en;

  assign cap_en = start;
  assign lo_en  = (phase == PH_VEC_LO);
  assign fin_en = (phase == PH_VEC_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      sp_q <= '0;
      st_q <= '0;
    end else if (cap_en) begin
      pc_q <= pc_in;
      sp_q <= sp_in;
      st_q <= status_in & ~B_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_en) lo_q <= bus_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      spo_q <= '0;
      sto_q <= '0;
    end else if (fin_en) begin
      vec_q <= {bus_rdata, lo_q};
      spo_q <= sp_q - DATA_W'(3);
      sto_q <= st_q | I_MASK;
    end
  end

  always_comb begin
    bus_addr  = '0;
    bus_rnw   = 1'b1;
    bus_wdata = '0;
    unique case (phase)
      PH_DUMMY1, PH_DUMMY2: bus_addr = pc_q;
      PH_PUSH_HI: begin
        bus_addr  = {PAGE, sp_q};
        bus_rnw   = 1'b0;
        bus_wdata = pc_q[ADDR_W-1:DATA_W];
      end
      PH_PUSH_LO: begin
        bus_addr  = {PAGE, sp_q - DATA_W'(1)};
        bus_rnw   = 1'b0;
        bus_wdata = pc_q[DATA_W-1:0];
      end
      PH_PUSH_ST: begin
        bus_addr  = {PAGE, sp_q - DATA_W'(2)};
        bus_rnw   = 1'b0;
        bus_wdata = st_q;
      end
      PH_VEC_LO: bus_addr = VEC_LO_A;
      PH_VEC_HI: bus_addr = VEC_HI_A;
      default: ;
    endcase
  end

  assign vector_pc  = vec_q;
  assign sp_out     = spo_q;
  assign status_out = sto_q;

  // R6: every write lands on the stack page
  a_r6_push_page: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rnw |-> (bus_addr[ADDR_W-1:DATA_W] == PAGE));
  // R5: both dummy reads use the same address
  a_r5_dummy_same: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DUMMY2) |-> (bus_rnw && $stable(bus_addr)));
  // R9: captured values hold through the entry
  a_r9_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && phase != PH_DUMMY1) |-> ($stable(pc_q) && $stable(sp_q)));
  // R7: vector high fetch follows the low fetch
  a_r7_vec_order: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_VEC_HI) |-> ($past(bus_addr) == VEC_LO_A && bus_rnw));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned SEEN_EDGES = 2,
  parameter int unsigned DATA_W     = 8,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VEC_ADDR   = 16'hFFFE,
  parameter int unsigned I_BIT      = 2,
  parameter int unsigned B_BIT      = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                irq_n,
  input  logic                irq_disable,
  input  logic                insn_done,
  input  logic [2*DATA_W-1:0] pc_in,
  input  logic [DATA_W-1:0]   sp_in,
  input  logic [DATA_W-1:0]   status_in,
  input  logic [DATA_W-1:0]   bus_rdata,
  output logic [2*DATA_W-1:0] bus_addr,
  output logic                bus_rnw,
  output logic [DATA_W-1:0]   bus_wdata,
  output logic                entry_busy,
  output logic                entry_done,
  output logic [2*DATA_W-1:0] vector_pc,
  output logic [DATA_W-1:0]   sp_out,
  output logic [DATA_W-1:0]   status_out
);
  logic   pending, start;
  phase_e phase;

  irq_req_sampler #(.SEEN_EDGES(SEEN_EDGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .pending(pending)
  );

  irq_entry_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pending(pending), .irq_disable(irq_disable),
    .insn_done(insn_done), .phase(phase), .start(start),
    .busy(entry_busy), .done(entry_done)
  );

  irq_entry_datapath #(
    .DATA_W(DATA_W), .STACK_PAGE(STACK_PAGE), .VEC_ADDR(VEC_ADDR),
    .I_BIT(I_BIT), .B_BIT(B_BIT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .phase(phase), .start(start),
    .pc_in(pc_in), .sp_in(sp_in), .status_in(status_in), .bus_rdata(bus_rdata),
    .bus_addr(bus_addr), .bus_rnw(bus_rnw), .bus_wdata(bus_wdata),
    .vector_pc(vector_pc), .sp_out(sp_out), .status_out(status_out)
  );
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n, irq_n, irq_disable, insn_done;
  logic [15:0] pc_in, bus_addr, vector_pc;
  logic [7:0]  sp_in, status_in, bus_rdata, bus_wdata, sp_out, status_out;
  logic        bus_rnw, entry_busy, entry_done;

  always #4 clk = ~clk;

  irq_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .irq_disable(irq_disable),
    .insn_done(insn_done), .pc_in(pc_in), .sp_in(sp_in), .status_in(status_in),
    .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_rnw(bus_rnw),
    .bus_wdata(bus_wdata), .entry_busy(entry_busy), .entry_done(entry_done),
    .vector_pc(vector_pc), .sp_out(sp_out), .status_out(status_out)
  );

  int n_tests = 0, n_fail = 0, m_starts = 0;
  bit summary_done = 0, busy_seen = 0;
  int m_cnt, m_phase;
  bit m_done;
  logic [15:0] m_pc;
  logic [7:0]  m_sp, m_st, m_lo, m_hi, vlo, vhi;

  function automatic logic [7:0] mem_rd(input logic [15:0] a);
    if (a == 16'hFFFE) return vlo;
    if (a == 16'hFFFF) return vhi;
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_phase = 0; m_done = 0;
  endtask

  // one processor cycle: compare at the falling edge, drive, then advance the model
  task automatic step(input logic irq, input logic ins, input logic ifl,
                      input logic [15:0] p, input logic [7:0] s, input logic [7:0] st);
    logic [15:0] ea; logic ernw; logic [7:0] ewd; string req;
    logic [7:0] rd;
    @(negedge clk);
    ea = 16'h0; ernw = 1'b1; ewd = 8'h0; req = "R10 idle";
    case (m_phase)
      1, 2: begin ea = m_pc; req = "R5 dummy read"; end
      3: begin ea = {8'h01, m_sp}; ernw = 0; ewd = m_pc[15:8]; req = "R6 push hi"; end
      4: begin ea = {8'h01, m_sp - 8'd1}; ernw = 0; ewd = m_pc[7:0]; req = "R6 push lo"; end
      5: begin ea = {8'h01, m_sp - 8'd2}; ernw = 0; ewd = m_st & ~8'h10; req = "R6 push status"; end
      6: begin ea = 16'hFFFE; req = "R7 vector lo"; end
      7: begin ea = 16'hFFFF; req = "R7 vector hi"; end
      default: ;
    endcase
    if (entry_busy) busy_seen = 1;
    check({entry_busy, bus_rnw, bus_addr, bus_wdata, entry_done} ==
          {m_phase != 0, ernw, ea, ewd, m_done}, req,
          {38'h0, entry_busy, bus_rnw, bus_addr, bus_wdata, entry_done},
          {38'h0, m_phase != 0, ernw, ea, ewd, m_done});
    if (m_done)
      check({vector_pc, sp_out, status_out} == {m_hi, m_lo, m_sp - 8'd3, (m_st & ~8'h10) | 8'h04},
            "R8 results", {32'h0, vector_pc, sp_out, status_out},
            {32'h0, m_hi, m_lo, m_sp - 8'd3, (m_st & ~8'h10) | 8'h04});
    rd = mem_rd(bus_addr);
    irq_n = irq; insn_done = ins; irq_disable = ifl;
    pc_in = p; sp_in = s; status_in = st; bus_rdata = rd;
    @(posedge clk);
    // model advance from the requirements (R2..R10)
    begin
      bit pend; int nph; bit ndone;
      pend = (m_cnt >= 2);
      ndone = (m_phase == 7);
      nph = 0;
      if (m_phase == 0) begin
        if (!m_done && ins && pend && !ifl) begin
          nph = 1; m_pc = p; m_sp = s; m_st = st; m_starts++;
        end
      end else if (m_phase < 7) nph = m_phase + 1;
      if (m_phase == 6) m_lo = mem_rd(16'hFFFE);
      if (m_phase == 7) m_hi = mem_rd(16'hFFFF);
      m_phase = nph; m_done = ndone;
      m_cnt = irq ? 0 : ((m_cnt >= 2) ? 2 : m_cnt + 1);
    end
  endtask

  task automatic rstep(input logic irq, input logic ins, input logic ifl);
    step(irq, ins, ifl, 16'($urandom), 8'($urandom), 8'($urandom));
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int s0;
    void'($urandom(32'h1D5E_7A11));
    vlo = 8'h34; vhi = 8'hC2;
    rst_n = 0; irq_n = 1; irq_disable = 0; insn_done = 0;
    pc_in = 0; sp_in = 0; status_in = 0; bus_rdata = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check({entry_busy, bus_rnw, bus_addr, bus_wdata, entry_done} == {1'b0, 1'b1, 16'h0, 8'h0, 1'b0},
          "R1 reset state", {38'h0, entry_busy, bus_rnw, bus_addr, bus_wdata, entry_done},
          {38'h0, 1'b0, 1'b1, 16'h0, 8'h0, 1'b0});
    rst_n = 1;
    repeat (3) rstep(1, 1, 0);

    // R2: low pulse seen at one edge only
    busy_seen = 0; s0 = m_starts;
    rstep(0, 1, 0);
    repeat (8) rstep(1, 1, 0);
    check(!busy_seen, "R2 one-edge pulse ignored", {63'h0, busy_seen}, 64'h0);

    // R4: masked request, then unmasked
    busy_seen = 0;
    repeat (8) rstep(0, 1, 1);
    check(!busy_seen, "R4 masked request", {63'h0, busy_seen}, 64'h0);
    rstep(0, 1, 0);
    repeat (10) rstep(1, 0, 1);
    check(busy_seen, "R4 entry after unmask", {63'h0, busy_seen}, 64'h1);
    rstep(1, 0, 0);

    // R3: no boundary, no entry
    busy_seen = 0;
    repeat (6) rstep(0, 0, 0);
    check(!busy_seen, "R3 waits for boundary", {63'h0, busy_seen}, 64'h0);
    rstep(0, 1, 0);
    repeat (10) rstep(1, 0, 1);
    check(busy_seen, "R3 entry at boundary", {63'h0, busy_seen}, 64'h1);

    // R6: stack pointer wrap, register inputs changing each cycle (R9)
    vlo = 8'h00; vhi = 8'h80;
    rstep(0, 0, 0); rstep(0, 0, 0);
    step(0, 1, 0, 16'hABCD, 8'h01, 8'hFF);
    repeat (10) rstep(1, 0, 1);
    rstep(1, 0, 0);

    // random mix
    begin
      logic ir = 1;
      for (int k = 0; k < 4000; k++) begin
        if (($urandom % 6) == 0) ir = ~ir;
        if (m_phase == 0 && !m_done) begin vlo = 8'($urandom); vhi = 8'($urandom); end
        rstep(ir, ($urandom % 3) == 0, ($urandom % 8) == 0);
      end
    end
    check(m_starts - s0 > 10, "R3 entries occurred in random run", 64'(m_starts - s0), 64'd11);
    finish_run();
  end
endmodule